// File: doc/BRIEF.md
# Wakeup Interrupt Polarity Converter

This block sits between a bank of interrupt or wakeup input pins and a downstream interrupt controller that accepts only two trigger forms: an active-high level and a rising edge. Each pin carries a 3-bit sense code and an enable bit. The block brings every input through a two-flop synchroniser. It then converts active-low levels into active-high levels. Falling, rising and dual edges all become single-cycle high pulses, so the controller always sees one of its two accepted forms.

Software programs the block through a small word-addressed register interface. One config word per pin holds the sense code. Packed enable words hold 32 pins each. Changing one pin's enable is done by software as a read-modify-write of its word. Pin count is a parameter, up to 168 pins.

Top module: `wake_polarity_front`

## Requirements
- R1: After reset every `irq_out` bit is low and every mapped register reads zero.
- R2: Sense code 100 (level, active high): while the pin is enabled, `irq_out` equals the pin input, delayed by three clock edges. Two edges are for synchronisation and one is for the output register.
- R3: Sense code 000 (level, active low): while the pin is enabled, `irq_out` is the inverse of the pin input, with the same three-edge delay.
- R4: Sense code 110 (rising edge): each low-to-high input transition gives a `irq_out` pulse that is high for exactly one cycle, three edges later. A high-to-low transition gives nothing.
- R5: Sense code 010 (falling edge): each high-to-low input transition gives a one-cycle `irq_out` pulse three edges later. A rising transition gives nothing.
- R6: Sense code 111 (dual edge): every input transition, in either direction, gives a one-cycle `irq_out` pulse three edges later.
- R7: A disabled pin drives `irq_out` low from the edge after its enable bit clears. The pin's edge history keeps tracking the input while it is disabled, so enabling an edge-mode pin whose input is steady gives no pulse.
- R8: Sense codes 001, 011 and 101 are undefined. They are stored and read back unchanged, but the pin's output stays low even when it is enabled.
- R9: The enable word for pin p sits at byte offset 0x10 + 4*(p/32), with the pin's enable in bit p%32. The config word for pin p sits at 0x110 + 4*p. The sense code is in bits 2:0 of that word, and bits 31:3 read as zero.
- R10: A write to one enable word changes no other enable word. Enable bits for pin numbers at or above the pin count read as zero.
- R11: Offsets that are not word aligned, and offsets outside the enable and config ranges, read as zero. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_in | input | NUM_PINS | Asynchronous interrupt or wakeup inputs |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe; the write takes effect on the clock edge |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address while `bus_sel` is high |
| irq_out | output | NUM_PINS | Converted outputs to the downstream controller |

## Verification
Each sense mode is driven with both a rising and a falling input transition. This shows which direction each edge mode responds to, and whether level modes follow or invert the input. Each check is placed on the exact cycle of the output change, and the cycles either side of an edge pulse are checked too, so an extra or stretched pulse is caught.

Three further patterns cover the gating cases:
- inputs that toggle while their pin is disabled;
- a pin enabled while its input is already high;
- pins given undefined codes.

Between them these separate correct gating from a spurious edge produced when a pin is enabled. Register accesses probe word boundaries, bits above the pin count, and unmapped offsets.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  localparam int ENABLE_BASE = 'h010;
  localparam int CONFIG_BASE = 'h110;
  localparam int MAX_PINS    = 168;

  typedef enum logic [2:0] {
    SENSE_LVL_LO = 3'b000,
    SENSE_FALL   = 3'b010,
    SENSE_LVL_HI = 3'b100,
    SENSE_RISE   = 3'b110,
    SENSE_DUAL   = 3'b111
  } sense_e;
endpackage

// File: rtl/wpc_sync.sv
module wpc_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] meta_d, stab_d;

  always_comb begin
    meta_d = d;
    stab_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= meta_d;
      q      <= stab_d;
    end
  end
endmodule

// File: rtl/wpc_regs.sv
module wpc_regs
  import wpc_pkg::*;
#(
  parameter int NUM_PINS = 40,
  parameter int ADDR_W   = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic [NUM_PINS-1:0]   en_q,
  output logic [3*NUM_PINS-1:0] cfg_q
);
  localparam int NUM_WORDS = (NUM_PINS + 31) / 32;

  logic                  wr;
  logic [NUM_WORDS*32-1:0] en_pad;

  assign wr = bus_sel & bus_we;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam logic [ADDR_W-1:0] EN_ADDR  = ADDR_W'(ENABLE_BASE + 4 * (p / 32));
    localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(CONFIG_BASE + 4 * p);
    logic       en_r, en_d;
    logic [2:0] cfg_r, cfg_d;

    always_comb begin
      en_d  = en_r;
      cfg_d = cfg_r;
      if (wr && bus_addr == EN_ADDR)  en_d  = bus_wdata[p % 32];
      if (wr && bus_addr == CFG_ADDR) cfg_d = bus_wdata[2:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_r  <= 1'b0;
        cfg_r <= 3'b000;
      end else begin
        en_r  <= en_d;
        cfg_r <= cfg_d;
      end
    end

    assign en_q[p]        = en_r;
    assign cfg_q[3*p +: 3] = cfg_r;
  end

  assign en_pad = {{(NUM_WORDS*32-NUM_PINS){1'b0}}, en_q};

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      for (int w = 0; w < NUM_WORDS; w++)
        if (bus_addr == ADDR_W'(ENABLE_BASE + 4 * w)) bus_rdata = en_pad[w*32 +: 32];
      for (int p = 0; p < NUM_PINS; p++)
        if (bus_addr == ADDR_W'(CONFIG_BASE + 4 * p)) bus_rdata = {29'b0, cfg_q[3*p +: 3]};
    end
  end
endmodule

// File: rtl/wpc_pin_conv.sv
module wpc_pin_conv
  import wpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sense,
  input  logic       enable,
  input  logic       level_s,
  output logic       irq
);
  logic hist_q, hist_d;
  logic irq_d;
  logic rise, fall, fwd;

  always_comb begin
    rise   = level_s & ~hist_q;
    fall   = ~level_s & hist_q;
    hist_d = level_s;
    case (sense)
      SENSE_LVL_LO: fwd = ~level_s;
      SENSE_LVL_HI: fwd = level_s;
      SENSE_RISE:   fwd = rise;
      SENSE_FALL:   fwd = fall;
      SENSE_DUAL:   fwd = rise | fall;
      default:      fwd = 1'b0;
    endcase
    irq_d = enable & fwd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      hist_q <= hist_d;
      irq    <= irq_d;
    end
  end
endmodule

// File: rtl/wake_polarity_front.sv
module wake_polarity_front
  import wpc_pkg::*;
#(
  parameter int NUM_PINS = 40,
  parameter int ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [NUM_PINS-1:0] irq_out
);
  logic                  rst_meta_q, rst_sync_n;
  logic [NUM_PINS-1:0]   pin_s;
  logic [NUM_PINS-1:0]   en_q;
  logic [3*NUM_PINS-1:0] cfg_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  wpc_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(pin_in), .q(pin_s)
  );

  wpc_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .en_q(en_q), .cfg_q(cfg_flat)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_conv
    wpc_pin_conv u_conv (
      .clk(clk), .rst_n(rst_sync_n), .sense(cfg_flat[3*p +: 3]),
      .enable(en_q[p]), .level_s(pin_s[p]), .irq(irq_out[p])
    );
  end
endmodule

// File: rtl/wpc_checker.sv
module wpc_checker #(
  parameter int NUM_PINS = 40,
  parameter int ADDR_W   = 12
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_PINS-1:0]   pin_in,
  input logic [NUM_PINS-1:0]   irq_out,
  input logic [NUM_PINS-1:0]   en_q,
  input logic [3*NUM_PINS-1:0] cfg_flat,
  input logic                  bus_sel,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [31:0]           bus_rdata
);
  localparam int NUM_WORDS = (NUM_PINS + 31) / 32;

  int unsigned a;
  logic unmapped;

  always_comb begin
    a = 32'(bus_addr);
    unmapped = (a[1:0] != 2'b00) ||
               !((a >= 32'h10 && a < 32'h10 + 4 * NUM_WORDS) ||
                 (a >= 32'h110 && a < 32'h110 + 4 * NUM_PINS));
  end

  // R11: unmapped offsets read as zero
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && unmapped) |-> (bus_rdata == 32'h0));

  // R7: a disabled pin never drives its output
  p_disabled_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_out & ~$past(en_q)) == '0));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [2:0] code;
    assign code = cfg_flat[3*p +: 3];

    // R8: undefined codes keep the output quiet
    p_undef_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(code) == 3'b001 || $past(code) == 3'b011 || $past(code) == 3'b101)
        |-> !irq_out[p]);

    // R2: level-high output follows the input three edges later
    p_level_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en_q[p]) && $past(code) == 3'b100) |-> (irq_out[p] == $past(pin_in[p], 3)));

    // R4: rise/fall pulses last a single cycle
    p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(code, 2) == 3'b110 && $past(code) == 3'b110 && $past(irq_out[p])) ||
       ($past(code, 2) == 3'b010 && $past(code) == 3'b010 && $past(irq_out[p])))
        |-> !irq_out[p]);
  end
endmodule

bind wake_polarity_front wpc_checker #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .irq_out(irq_out), .en_q(en_q),
  .cfg_flat(cfg_flat), .bus_sel(bus_sel), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/wake_polarity_front_bench.sv
module wake_polarity_front_bench;
  localparam int NP = 40;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic          sel = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] irq;

  int cyc = 0;
  int checks = 0;
  int fails = 0;

  typedef struct { int at; int pin; bit val; string tag; } exp_t;
  exp_t sb[$];

  wake_polarity_front #(.NUM_PINS(NP), .ADDR_W(AW)) u_wake_polarity_front (
    .clk(clk), .rst_n(rst_n), .pin_in(pins), .bus_sel(sel), .bus_we(we),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_out(irq)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pop due items and compare
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (e.at < cyc || irq[e.pin] !== e.val) begin
        fails++;
        $display("FAIL %s: pin %0d at cycle %0d actual %0b expected %0b",
                 e.tag, e.pin, e.at, irq[e.pin], e.val);
      end
    end
  end

  task automatic expect_at(int d, int p, bit v, string tag);
    exp_t e;
    e.at = cyc + d; e.pin = p; e.val = v; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic bus_write(int a, logic [31:0] d);
    sel = 1'b1; we = 1'b1; addr = AW'(a); wdata = d;
    @(posedge clk); @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(int a, logic [31:0] exp, string tag);
    sel = 1'b1; we = 1'b0; addr = AW'(a);
    #1;
    checks++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s: read 0x%0h actual 0x%0h expected 0x%0h", tag, a, rdata, exp);
    end
    sel = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    // R1: reset state
    checks++;
    if (irq !== '0) begin
      fails++; $display("FAIL R1: irq actual 0x%0h expected 0", irq);
    end
    bus_read('h10, 0, "R1");
    bus_read('h14, 0, "R1");
    bus_read('h110, 0, "R1");

    // configuration; R9 layout
    bus_write('h110 + 4*3,  32'hABCD_0004);
    bus_write('h110 + 4*33, 32'h0);
    bus_write('h110 + 4*5,  32'h6);
    bus_write('h110 + 4*6,  32'h2);
    bus_write('h110 + 4*7,  32'h7);
    bus_write('h110 + 4*8,  32'h6);
    bus_write('h110 + 4*9,  32'h7);
    bus_write('h110 + 4*10, 32'h5);
    bus_write('h110 + 4*11, 32'h1);
    bus_write('h110 + 4*12, 32'h3);
    bus_write('h10, 32'h0000_1CE8);
    bus_write('h14, 32'h0000_0002);
    expect_at(1, 33, 1'b1, "R3");
    bus_read('h10, 32'h1CE8, "R9");
    bus_read('h14, 32'h2, "R9");
    bus_read('h110 + 4*3, 32'h4, "R9");
    bus_read('h110 + 4*7, 32'h7, "R9");
    bus_read('h110 + 4*10, 32'h5, "R8");
    bus_read('h110 + 4*11, 32'h1, "R8");
    bus_read('h110 + 4*12, 32'h3, "R8");
    idle(4);

    // R2: level high
    pins[3] = 1'b1;
    expect_at(2, 3, 1'b0, "R2"); expect_at(3, 3, 1'b1, "R2"); expect_at(5, 3, 1'b1, "R2");
    idle(6);
    pins[3] = 1'b0;
    expect_at(2, 3, 1'b1, "R2"); expect_at(3, 3, 1'b0, "R2");
    idle(6);

    // R3: level low
    pins[33] = 1'b1;
    expect_at(2, 33, 1'b1, "R3"); expect_at(3, 33, 1'b0, "R3");
    idle(6);
    pins[33] = 1'b0;
    expect_at(3, 33, 1'b1, "R3");
    idle(6);

    // R4: rising edge
    pins[5] = 1'b1;
    expect_at(2, 5, 1'b0, "R4"); expect_at(3, 5, 1'b1, "R4"); expect_at(4, 5, 1'b0, "R4");
    idle(6);
    pins[5] = 1'b0;
    expect_at(3, 5, 1'b0, "R4"); expect_at(4, 5, 1'b0, "R4");
    idle(6);

    // R5: falling edge
    pins[6] = 1'b1;
    expect_at(3, 6, 1'b0, "R5"); expect_at(4, 6, 1'b0, "R5");
    idle(6);
    pins[6] = 1'b0;
    expect_at(2, 6, 1'b0, "R5"); expect_at(3, 6, 1'b1, "R5"); expect_at(4, 6, 1'b0, "R5");
    idle(6);

    // R6: dual edge
    pins[7] = 1'b1;
    expect_at(2, 7, 1'b0, "R6"); expect_at(3, 7, 1'b1, "R6"); expect_at(4, 7, 1'b0, "R6");
    idle(6);
    pins[7] = 1'b0;
    expect_at(3, 7, 1'b1, "R6"); expect_at(4, 7, 1'b0, "R6");
    idle(6);

    // R8: undefined codes enabled stay quiet
    pins[10] = 1'b1; pins[11] = 1'b1; pins[12] = 1'b1;
    expect_at(3, 10, 1'b0, "R8"); expect_at(3, 11, 1'b0, "R8"); expect_at(3, 12, 1'b0, "R8");
    idle(6);

    // R7: disabled pins, enable without spurious edge, disable gating
    pins[9] = 1'b1;
    expect_at(3, 9, 1'b0, "R7");
    pins[8] = 1'b1;
    expect_at(3, 8, 1'b0, "R7");
    idle(6);
    bus_write('h10, 32'h0000_1DE8);
    expect_at(1, 8, 1'b0, "R7"); expect_at(2, 8, 1'b0, "R7"); expect_at(3, 8, 1'b0, "R7");
    idle(5);
    pins[3] = 1'b1;
    expect_at(3, 3, 1'b1, "R2");
    idle(5);
    bus_write('h10, 32'h0000_1DE0);
    expect_at(1, 3, 1'b0, "R7"); expect_at(3, 3, 1'b0, "R7");
    idle(5);

    // R10: word independence and bits above pin count
    bus_read('h14, 32'h2, "R10");
    bus_write('h14, 32'hFFFF_FFFF);
    bus_read('h14, 32'h0000_00FF, "R10");
    bus_read('h10, 32'h1DE0, "R10");
    bus_write('h14, 32'h2);
    bus_read('h14, 32'h2, "R10");

    // R11: unmapped offsets
    bus_read('h000, 0, "R11");
    bus_read('h018, 0, "R11");
    bus_read('h110 + 4*NP, 0, "R11");
    bus_read('h111, 0, "R11");
    bus_write('h000, 32'hFFFF_FFFF);
    bus_write('h018, 32'hFFFF_FFFF);
    bus_write('h111, 32'h7);
    bus_write('h110 + 4*NP, 32'h7);
    bus_read('h10, 32'h1DE0, "R11");
    bus_read('h14, 32'h2, "R11");
    bus_read('h110, 32'h0, "R11");
    bus_read('h110 + 4*(NP-1), 32'h0, "R11");

    idle(8);
    wait (sb.size() == 0);
    idle(2);
    finish_run();
  end
endmodule